// File: doc/BRIEF.md
# Framed Serial Channel Register and FIFO Interface

This block is the host-facing side of one channel of a frame-oriented serial controller. Software programs it through one packed 32-bit control write and watches it through one 32-bit status word. Transmit bytes go into a byte FIFO. The serial engine pulls them one at a time. Received bytes from the engine collect in a second FIFO, which the host drains. The bit-level engine (flags, stuffing, CRC arithmetic) sits outside the block. It looks like a byte sink with a request strobe and a byte source with end, CRC-good and abort qualifiers.

A transmit load starts with a control write. The write gives the number of bytes that follow and says whether the last of them closes a frame. The host then pushes that many bytes. Three events are reported in the status word and on `irq`: transmit FIFO drained, transmit underrun and receive chunk ready. Each receive chunk reports its byte count and, at a frame end, the CRC and abort result. Reset bits in the control write flush either direction and keep it idle while they stay set. A loopback mode feeds transmitted bytes straight into the receive FIFO.

Top module: `hdlcChanIf`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0, `txValid` is 0 and `rxNotEmpty` is 0.
- R2: Control write fields are: command = bits 7:0, load length = bits 13:8, mode = bits 23:16. After a write with a nonzero length N, exactly the next N pushed bytes are accepted, in order. A length of 0 accepts DEPTH bytes. Pushes beyond the load or into a full FIFO are dropped.
- R3: With command bit 0 set (flag-framed mode, mode bit 0), the last byte of the load is presented with `txEnd`=1 and all other bytes with `txEnd`=0.
- R4: Status bit 7 (transmit ready) is set when a `txReq` pop empties the transmit FIFO.
- R5: Status bit 6 (underrun) is set when `txReq` finds the transmit FIFO empty after a byte without end mark was sent. It is not set when the last byte sent carried the end mark.
- R6: While command bit 7 is held, the transmit FIFO is empty, `txValid` is 0 and pushes are dropped.
- R7: A received byte with `rxEnd` raises status bit 5. It loads status bits 13:8 with the chunk byte count and sets bit 0. Bit 1 gets CRC-good, bit 2 gets not-aborted and bit 3 gets aborted, so a good frame shows bits 3:1 = 011.
- R8: When DEPTH bytes have arrived since the last receive event without an end, status bit 5 is raised with a length of DEPTH and bits 3:0 cleared.
- R9: A received byte arriving at a full receive FIFO is dropped. It sets status bit 4 (sticky) and raises bit 5.
- R10: While command bit 5 is held, the receive FIFO is flushed and status bits 13:8 and 4:0 read 0.
- R11: In transparent mode (mode bit 1), command bit 0 never marks an end byte, and a received `rxEnd` does not raise a receive event.
- R12: A status read (`statRdEn`) clears bits 7:5 after that cycle. `irq` is the OR of bits 7:5.
- R13: In loopback mode (mode bit 7), each popped transmit byte is written into the receive FIFO with its end mark, and CRC-good is taken as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Packed control word |
| dataWrEn | input | 1 | Transmit byte push strobe |
| dataWrData | input | 8 | Transmit byte |
| dataRdEn | input | 1 | Receive byte pop strobe |
| dataRdData | output | 8 | Receive FIFO head byte |
| rxNotEmpty | output | 1 | Receive FIFO holds data |
| statRdEn | input | 1 | Status read strobe (clears event flags) |
| statusWord | output | 32 | Packed status word |
| irq | output | 1 | Any event flag set |
| engineMode | output | 8 | Current mode byte for the serial engine |
| txReq | input | 1 | Engine requests the next byte |
| txValid | output | 1 | Transmit FIFO head is valid |
| txByte | output | 8 | Transmit FIFO head byte |
| txEnd | output | 1 | Head byte closes a frame |
| rxValid | input | 1 | Engine delivers a byte |
| rxByte | input | 8 | Received byte |
| rxEnd | input | 1 | Byte closes a frame |
| rxCrcOk | input | 1 | Frame CRC is good (with rxEnd) |
| rxAbort | input | 1 | Frame was aborted (with rxEnd) |

## Verification
The bench builds the block with the default DEPTH of 32, so the 6-bit length field can hold a full FIFO exactly. That makes the zero-means-full load, the 32-byte receive threshold and the overflow on the 33rd byte all reachable with short byte streams. Tables of transmit loads cover exact, full and zero lengths with and without end marks and in transparent mode. Directed sequences then cover underrun, both reset holds, each frame-end status pattern and loopback.

// File: rtl/hdlcChanPkg.sv
package hdlcChanPkg;
  // width of the length fields in the packed words
  localparam int LEN_W = 6;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic txFlush;
    logic txPush;
    logic txPushEnd;
    logic txPop;
    logic rxFlush;
    logic rxPush;
    logic rxPop;
    logic rxFromTx;
  } chanStrb_t;
endpackage

// File: rtl/hdlcByteFifo.sv
module hdlcByteFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             oneLeft
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign oneLeft = (count == CW'(1));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign dout    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= din;
  end

  // R2: occupancy never passes the depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/hdlcChanData.sv
module hdlcChanData
  import hdlcChanPkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  chanStrb_t strb,
  input  logic [7:0] txByteIn,
  input  logic [7:0] rxByteIn,
  output logic [7:0] txHeadByte,
  output logic      txHeadEnd,
  output logic      txEmpty,
  output logic      txFull,
  output logic      txLast,
  output logic [7:0] rxHeadByte,
  output logic      rxEmpty,
  output logic      rxFull
);
  logic [8:0] txDin, txDout;
  logic [7:0] rxDin;
  logic       unusedRxOne;

  assign txDin      = {strb.txPushEnd, txByteIn};
  assign txHeadByte = txDout[7:0];
  assign txHeadEnd  = txDout[8];

  // loopback picks the transmit head as receive source
  assign rxDin = strb.rxFromTx ? txDout[7:0] : rxByteIn;

  hdlcByteFifo #(.WIDTH(9), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush), .push(strb.txPush),
    .pop(strb.txPop), .din(txDin), .dout(txDout), .empty(txEmpty),
    .full(txFull), .oneLeft(txLast)
  );

  hdlcByteFifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush), .push(strb.rxPush),
    .pop(strb.rxPop), .din(rxDin), .dout(rxHeadByte), .empty(rxEmpty),
    .full(rxFull), .oneLeft(unusedRxOne)
  );

  // R13: loopback writes come only from a transmit pop
  p_loop_src_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxFromTx && strb.rxPush) |-> strb.txPop);
endmodule

// File: rtl/hdlcChanCtrl.sv
module hdlcChanCtrl
  import hdlcChanPkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  input  logic        dataWrEn,
  input  logic        dataRdEn,
  input  logic        statRdEn,
  input  logic        txReq,
  input  logic        rxValid,
  input  logic        rxEnd,
  input  logic        rxCrcOk,
  input  logic        rxAbort,
  input  logic        txEmpty,
  input  logic        txFull,
  input  logic        txLast,
  input  logic        txHeadEnd,
  input  logic        rxEmpty,
  input  logic        rxFull,
  output chanStrb_t   strb,
  output logic [31:0] statusWord,
  output logic        irq,
  output logic [7:0]  engineMode
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [7:0]       wrCmd, wrMode;
  logic [LEN_W-1:0] wrLen;
  logic             unusedBits;

  logic             txHold, rxHold;
  logic [7:0]       modeReg;
  logic [LEN_W-1:0] loadLeft;
  logic             loadEnd, inFrame;
  logic [2:0]       flags;
  logic [CW-1:0]    rxAvail, availNext;
  logic [LEN_W-1:0] rxLen;
  logic [4:0]       rxStat;

  logic txRst, rxRst, loop, trans, popOk;
  logic inValid, inEnd, inCrc, inAbort;
  logic underEvt, txDoneEvt, ovfEvt, effEnd, rxEvt;

  assign wrCmd      = ctrlWrData[7:0];
  assign wrLen      = ctrlWrData[8 +: LEN_W];
  assign wrMode     = ctrlWrData[23:16];
  assign unusedBits = ^{ctrlWrData[31:24], ctrlWrData[15:14], wrCmd[6], wrCmd[4:1]};

  assign txRst = txHold || (ctrlWrEn && wrCmd[7]);
  assign rxRst = rxHold || (ctrlWrEn && wrCmd[5]);
  assign loop  = modeReg[7];
  assign trans = modeReg[1];
  assign popOk = txReq && !txEmpty && !txRst;

  // receive input selection
  assign inValid = loop ? popOk : rxValid;
  assign inEnd   = loop ? txHeadEnd : rxEnd;
  assign inCrc   = loop ? 1'b1 : rxCrcOk;
  assign inAbort = !loop && rxAbort;

  always_comb begin
    strb           = '0;
    strb.txFlush   = txRst;
    strb.txPush    = dataWrEn && !ctrlWrEn && !txRst && (loadLeft != '0) && !txFull;
    strb.txPushEnd = loadEnd && (loadLeft == LEN_W'(1));
    strb.txPop     = popOk;
    strb.rxFlush   = rxRst;
    strb.rxPush    = inValid && !rxFull && !rxRst;
    strb.rxPop     = dataRdEn && !rxEmpty && !rxRst;
    strb.rxFromTx  = loop;
  end

  assign underEvt  = txReq && txEmpty && inFrame && !txRst;
  assign txDoneEvt = popOk && txLast && !strb.txPush;
  assign ovfEvt    = inValid && rxFull && !rxRst;
  assign effEnd    = inValid && inEnd && !trans;
  assign availNext = rxAvail + CW'(strb.rxPush);
  assign rxEvt     = !rxRst && (ovfEvt || effEnd ||
                     (strb.rxPush && availNext == CW'(DEPTH)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold   <= 1'b0;
      rxHold   <= 1'b0;
      modeReg  <= '0;
      loadLeft <= '0;
      loadEnd  <= 1'b0;
      inFrame  <= 1'b0;
      flags    <= '0;
      rxAvail  <= '0;
      rxLen    <= '0;
      rxStat   <= '0;
    end else begin
      if (ctrlWrEn) begin
        txHold  <= wrCmd[7];
        rxHold  <= wrCmd[5];
        modeReg <= wrMode;
        if (wrCmd[7]) begin
          loadLeft <= '0;
          loadEnd  <= 1'b0;
        end else begin
          loadLeft <= (wrLen == '0) ? LEN_W'(DEPTH) : wrLen;
          loadEnd  <= wrCmd[0] && !wrMode[1];
        end
      end else if (strb.txPush) begin
        loadLeft <= loadLeft - LEN_W'(1);
      end

      if (txRst)      inFrame <= 1'b0;
      else if (popOk) inFrame <= !txHeadEnd;

      flags <= (statRdEn ? 3'b000 : flags) | {txDoneEvt, underEvt, rxEvt};

      if (rxRst) begin
        rxAvail <= '0;
        rxLen   <= '0;
        rxStat  <= '0;
      end else if (rxEvt) begin
        rxAvail <= '0;
        rxLen   <= LEN_W'(availNext);
        rxStat  <= {rxStat[4] | ovfEvt, effEnd && inAbort, effEnd && !inAbort,
                    effEnd && inCrc, effEnd};
      end else begin
        rxAvail <= availNext;
      end
    end
  end

  assign statusWord = {18'b0, rxLen, flags, rxStat};
  assign irq        = |flags;
  assign engineMode = modeReg;

  // R2: an accepted push always finds room
  p_push_room_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.txPush |-> !txFull);
  // R3: the end-marked push is the last one of its load
  p_end_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPush && strb.txPushEnd) |=> (loadLeft == '0));
  // R5: underrun only rises after an empty cycle
  p_under_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> $past(txEmpty));
  // R6: a held transmit reset leaves the FIFO empty
  p_flush_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    txHold |=> txEmpty);
  // R8: reported length never exceeds the depth
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxLen <= LEN_W'(DEPTH));
  // R10: a held receive reset empties FIFO and length
  p_flush_rx_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxHold |=> (rxEmpty && rxLen == '0));
  // R11: transparent mode never stores an end mark
  p_trans_no_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPush && trans) |-> !strb.txPushEnd);
  // R12: a read with no new event leaves all flags clear
  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (statRdEn && !txDoneEvt && !underEvt && !rxEvt) |=> (flags == 3'b000));
endmodule

// File: rtl/hdlcChanIf.sv
module hdlcChanIf
  import hdlcChanPkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  input  logic        dataWrEn,
  input  logic [7:0]  dataWrData,
  input  logic        dataRdEn,
  output logic [7:0]  dataRdData,
  output logic        rxNotEmpty,
  input  logic        statRdEn,
  output logic [31:0] statusWord,
  output logic        irq,
  output logic [7:0]  engineMode,
  input  logic        txReq,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txEnd,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        rxEnd,
  input  logic        rxCrcOk,
  input  logic        rxAbort
);
  chanStrb_t strb;
  logic txEmpty, txFull, txLast, txHeadEnd, rxEmpty, rxFull;

  hdlcChanCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .statRdEn(statRdEn),
    .txReq(txReq), .rxValid(rxValid), .rxEnd(rxEnd), .rxCrcOk(rxCrcOk),
    .rxAbort(rxAbort), .txEmpty(txEmpty), .txFull(txFull), .txLast(txLast),
    .txHeadEnd(txHeadEnd), .rxEmpty(rxEmpty), .rxFull(rxFull), .strb(strb),
    .statusWord(statusWord), .irq(irq), .engineMode(engineMode)
  );

  hdlcChanData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .txByteIn(dataWrData),
    .rxByteIn(rxByte), .txHeadByte(txByte), .txHeadEnd(txHeadEnd),
    .txEmpty(txEmpty), .txFull(txFull), .txLast(txLast),
    .rxHeadByte(dataRdData), .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

  assign txValid    = !txEmpty;
  assign txEnd      = txHeadEnd;
  assign rxNotEmpty = !rxEmpty;
endmodule

// File: tb/hdlcChanIf_bench.sv
module hdlcChanIf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0, dataWrEn = 1'b0, dataRdEn = 1'b0, statRdEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [7:0]  dataWrData = '0, rxByte = '0;
  logic        txReq = 1'b0, rxValid = 1'b0, rxEnd = 1'b0, rxCrcOk = 1'b0, rxAbort = 1'b0;
  logic [7:0]  dataRdData, engineMode, txByte;
  logic        rxNotEmpty, irq, txValid, txEnd;
  logic [31:0] statusWord;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  hdlcChanIf u_hdlcChanIf (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .dataRdEn(dataRdEn),
    .dataRdData(dataRdData), .rxNotEmpty(rxNotEmpty), .statRdEn(statRdEn),
    .statusWord(statusWord), .irq(irq), .engineMode(engineMode),
    .txReq(txReq), .txValid(txValid), .txByte(txByte), .txEnd(txEnd),
    .rxValid(rxValid), .rxByte(rxByte), .rxEnd(rxEnd), .rxCrcOk(rxCrcOk),
    .rxAbort(rxAbort)
  );

  typedef struct packed {
    logic [7:0] len;
    logic       endCmd;
    logic       transp;
    logic [7:0] expCnt;
    logic       expEnd;
  } txVec_t;

  localparam txVec_t VEC [6] = '{
    '{8'd5,  1'b1, 1'b0, 8'd5,  1'b1},
    '{8'd1,  1'b1, 1'b0, 8'd1,  1'b1},
    '{8'd0,  1'b0, 1'b0, 8'd32, 1'b0},
    '{8'd32, 1'b1, 1'b0, 8'd32, 1'b1},
    '{8'd7,  1'b1, 1'b1, 8'd7,  1'b0},
    '{8'd12, 1'b0, 1'b0, 8'd12, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrlWrite(input logic [7:0] cmd, input logic [7:0] len, input logic [7:0] mode);
    ctrlWrEn = 1'b1;
    ctrlWrData = {8'h00, mode, len, cmd};
    tick();
    ctrlWrEn = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    dataWrEn = 1'b1;
    dataWrData = b;
    tick();
    dataWrEn = 1'b0;
  endtask

  task automatic readStatus();
    statRdEn = 1'b1;
    tick();
    statRdEn = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b, input logic e, input logic crc, input logic ab);
    rxValid = 1'b1; rxByte = b; rxEnd = e; rxCrcOk = crc; rxAbort = ab;
    tick();
    rxValid = 1'b0; rxEnd = 1'b0; rxCrcOk = 1'b0; rxAbort = 1'b0;
  endtask

  task automatic drainTx(input logic [7:0] base, output int cnt, output logic lastEnd, output int bad);
    cnt = 0; lastEnd = 1'b0; bad = 0;
    while (txValid && cnt < 64) begin
      if (txByte !== base + 8'(cnt)) bad++;
      if (lastEnd) bad++;
      lastEnd = txEnd;
      txReq = 1'b1;
      tick();
      txReq = 1'b0;
      cnt++;
    end
  endtask

  task automatic readRx(input logic [7:0] base, output int cnt, output int bad);
    cnt = 0; bad = 0;
    while (rxNotEmpty && cnt < 64) begin
      if (dataRdData !== base + 8'(cnt)) bad++;
      dataRdEn = 1'b1;
      tick();
      dataRdEn = 1'b0;
      cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int cnt, bad;
    logic lastEnd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    chk("R1", statusWord, 32'h0);
    chk("R1", {29'b0, txValid, irq, rxNotEmpty}, 32'h0);

    // table of transmit loads: R2, R3, R4, R11
    foreach (VEC[i]) begin
      logic [7:0] mode;
      logic [7:0] base;
      mode = VEC[i].transp ? 8'h02 : 8'h01;
      base = 8'(8'h10 * i);
      ctrlWrite(8'h80, 8'h00, mode);
      ctrlWrite({7'b0, VEC[i].endCmd}, VEC[i].len, mode);
      readStatus();
      for (int k = 0; k < 40; k++) pushByte(base + 8'(k));
      drainTx(base, cnt, lastEnd, bad);
      chk("R2 count", 32'(cnt), 32'(VEC[i].expCnt));
      chk("R2 data", 32'(bad), 32'h0);
      chk(VEC[i].transp ? "R11 end" : "R3 end", {31'b0, lastEnd}, {31'b0, VEC[i].expEnd});
      chk("R4 ready", {29'b0, statusWord[7:5]}, 32'h4);
    end

    // R5: underrun after an open frame
    ctrlWrite(8'h80, 8'h00, 8'h01);
    ctrlWrite(8'h00, 8'd2, 8'h01);
    readStatus();
    pushByte(8'hA0); pushByte(8'hA1);
    drainTx(8'hA0, cnt, lastEnd, bad);
    txReq = 1'b1; tick(); txReq = 1'b0;
    chk("R5 under", {29'b0, statusWord[7:5]}, 32'h6);
    chk("R12 irq", {31'b0, irq}, 32'h1);
    readStatus();
    chk("R12 clear", {29'b0, statusWord[7:5]}, 32'h0);
    chk("R12 irq low", {31'b0, irq}, 32'h0);

    // R5: no underrun after an end-marked byte
    ctrlWrite(8'h80, 8'h00, 8'h01);
    ctrlWrite(8'h01, 8'd1, 8'h01);
    pushByte(8'hB0);
    drainTx(8'hB0, cnt, lastEnd, bad);
    txReq = 1'b1; tick(); txReq = 1'b0;
    chk("R5 closed", {31'b0, statusWord[6]}, 32'h0);
    readStatus();

    // R6: transmit reset hold
    ctrlWrite(8'h80, 8'h00, 8'h01);
    ctrlWrite(8'h00, 8'd3, 8'h01);
    pushByte(8'hC0); pushByte(8'hC1); pushByte(8'hC2);
    chk("R6 loaded", {23'b0, txValid, txByte}, {23'b0, 1'b1, 8'hC0});
    ctrlWrite(8'h80, 8'h00, 8'h01);
    chk("R6 flushed", {31'b0, txValid}, 32'h0);
    pushByte(8'hC3);
    chk("R6 held", {31'b0, txValid}, 32'h0);
    ctrlWrite(8'h00, 8'h00, 8'h01);

    // R7: receive frame ends
    ctrlWrite(8'hA0, 8'h00, 8'h01);
    ctrlWrite(8'h00, 8'h00, 8'h01);
    readStatus();
    for (int k = 0; k < 4; k++) rxSend(8'h10 + 8'(k), k == 3, 1'b1, 1'b0);
    chk("R7 good", {18'b0, statusWord[13:0]}, 32'h0427);
    readRx(8'h10, cnt, bad);
    chk("R7 data", 32'(cnt * 256 + bad), 32'h0400);
    readStatus();
    rxSend(8'h20, 1'b0, 1'b0, 1'b0);
    rxSend(8'h21, 1'b1, 1'b0, 1'b0);
    chk("R7 crc bad", {18'b0, statusWord[13:0]}, 32'h0225);
    readRx(8'h20, cnt, bad);
    readStatus();
    rxSend(8'h30, 1'b1, 1'b1, 1'b1);
    chk("R7 abort", {18'b0, statusWord[13:0]}, 32'h012B);
    readRx(8'h30, cnt, bad);
    readStatus();

    // R8: threshold event
    for (int k = 0; k < 31; k++) rxSend(8'h40 + 8'(k), 1'b0, 1'b0, 1'b0);
    chk("R8 below", {31'b0, statusWord[5]}, 32'h0);
    rxSend(8'h40 + 8'd31, 1'b0, 1'b0, 1'b0);
    chk("R8 full", {18'b0, statusWord[13:0]}, 32'h2020);
    readStatus();

    // R9: overflow
    rxSend(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R9 ovf", {18'b0, statusWord[13:0]}, 32'h0030);
    readRx(8'h40, cnt, bad);
    chk("R9 kept", 32'(cnt * 256 + bad), 32'h2000);
    readStatus();

    // R10: receive reset hold
    rxSend(8'h50, 1'b0, 1'b0, 1'b0);
    rxSend(8'h51, 1'b0, 1'b0, 1'b0);
    ctrlWrite(8'h20, 8'h00, 8'h01);
    chk("R10 flush", {20'b0, rxNotEmpty, statusWord[13:8], statusWord[4:0]}, 32'h0);
    rxSend(8'h52, 1'b1, 1'b1, 1'b0);
    chk("R10 held", {31'b0, rxNotEmpty}, 32'h0);
    ctrlWrite(8'h00, 8'h00, 8'h01);
    readStatus();

    // R11: transparent receive ignores frame end
    ctrlWrite(8'h00, 8'h00, 8'h02);
    for (int k = 0; k < 3; k++) rxSend(8'h60 + 8'(k), k == 2, 1'b1, 1'b0);
    chk("R11 no event", {30'b0, statusWord[5], statusWord[0]}, 32'h0);
    readRx(8'h60, cnt, bad);
    chk("R11 data", 32'(cnt * 256 + bad), 32'h0300);

    // R13: loopback
    ctrlWrite(8'hA0, 8'h00, 8'h81);
    ctrlWrite(8'h01, 8'd3, 8'h81);
    readStatus();
    for (int k = 0; k < 3; k++) pushByte(8'h70 + 8'(k));
    drainTx(8'h70, cnt, lastEnd, bad);
    chk("R13 status", {18'b0, statusWord[13:0]}, 32'h03A7);
    readRx(8'h70, cnt, bad);
    chk("R13 data", 32'(cnt * 256 + bad), 32'h0300);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule